// File: doc/BRIEF.md
# Serial Receive Engine with Idle Timeout and Error Status

This block turns an asynchronous serial input line into characters for a host-side reader. A bit timer runs from a fractional divisor, so the bit period is an integer plus a sixty-fourth fraction of the clock period. Each frame is validated at the middle of its start bit and then sampled at the middle of every later bit. Word length, the parity mode and the number of stop bits are all set by software. Each received character enters a 16-entry first-word-fall-through queue together with three per-character error marks.

A 32-bit status word carries the following:
- sticky error bits, each cleared by writing a one;
- the queue empty and full flags;
- a running count of accepted characters.

There are two interrupt outputs. One is a level interrupt, raised when the queue holds at least a set number of characters. The other fires when data has waited for an 11-bit programmable number of idle bit periods. A ready-to-receive output reflects queue occupancy when hardware flow control is on.

Top module: `serial_rx_engine`

## Requirements
- R1: The bit period is div_int + div_frac/64 clock cycles. A start is accepted on a high-to-low line transition. Data is sampled mid-bit, least significant bit first. word_len values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The data appears zero-extended in rd_data[7:0].
- R2: With parity_en set, a parity bit follows the data. parity_even=1 expects an even count of ones over data plus parity, and parity_even=0 expects an odd count. A mismatch sets the parity mark rd_data[9].
- R3: A zero on any stop bit sets the framing mark rd_data[8]. two_stop=1 means two stop bits are checked.
- R4: A frame whose bits after the start are all zero, including parity and stop bits, sets the break mark rd_data[10]. Each character carries at most one mark, with break taking precedence over parity and parity over framing.
- R5: Storing a character that carries a mark sets the matching sticky status bit: break at status[18], parity at status[17], framing at status[16]. err_clr bit i clears status bit 16+i, where bit 3 is overrun, 2 break, 1 parity and 0 framing. A new event in the same cycle wins over the clear.
- R6: A character that completes while the queue is full is dropped and sets overrun at status[19]. The stored characters and the count are unchanged.
- R7: The queue presents its oldest entry on rd_data. status[24] is empty and status[25] is full; all other status bits from 20 to 31 read zero. A pop when the queue is empty has no effect.
- R8: status[15:0] counts the characters accepted into the queue, modulo 65536, and is zero after reset.
- R9: While rx_en is low the line is ignored. No character is stored, and no error or count changes.
- R10: irq_level is high exactly when the queue holds 8 or more characters.
- R11: irq_timeout rises when rto_en is set, the queue is not empty, and rto_limit bit periods pass with no push and no pop. A push or pop drops it and restarts the wait. It stays low while the queue is empty or rto_en is low.
- R12: With flow_en set, rts_ready is low when the queue holds 14 or more characters and high otherwise. With flow_en clear, rts_ready is high.
- R13: A low pulse on the line that ends before the middle of the start bit does not produce a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| div_int | input | 16 | Integer part of the bit period in clocks |
| div_frac | input | 6 | Fraction of the bit period in 1/64 clock |
| word_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 even parity, 0 odd parity |
| two_stop | input | 1 | Two stop bits expected |
| rx_en | input | 1 | Receiver enable |
| rto_en | input | 1 | Idle timeout enable |
| rto_limit | input | 11 | Idle timeout in bit periods |
| flow_en | input | 1 | Flow control from queue occupancy |
| pop | input | 1 | Remove the oldest character |
| err_clr | input | 4 | Write-one-to-clear for status[19:16] |
| rd_data | output | 11 | {break, parity, framing, data[7:0]} of the oldest entry |
| status | output | 32 | Sticky errors, queue flags and received count |
| irq_level | output | 1 | Queue level interrupt |
| irq_timeout | output | 1 | Idle timeout interrupt |
| rts_ready | output | 1 | Remote may send |

## Verification
The bench goes after the following corner cases, and says what a wrong design would do in each:
- Break with a wrong parity bit, and parity error with a bad stop bit. A receiver that reported every mark, or applied the wrong priority, would show two marks, or the wrong one, on a single character.
- The seventeenth character into a full queue. A design that overwrote or shifted entries would change the first sixteen characters it hands back, or advance the count.
- A short low glitch, and characters arriving with the receiver disabled. A receiver without mid-bit validation, or one that ignored the enable, would store characters that should never appear.
- The idle timeout, with a pop partway through the wait. A counter that did not restart on a pop would fire early; one that ran while the queue was empty would fire with nothing waiting.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int DATA_W = 8;

   // status word bit positions
   localparam int ST_FRM  = 16;
   localparam int ST_PAR  = 17;
   localparam int ST_BRK  = 18;
   localparam int ST_OVR  = 19;
   localparam int ST_EMPT = 24;
   localparam int ST_FULL = 25;

   typedef struct packed {
      logic              brk;
      logic              par;
      logic              frm;
      logic [DATA_W-1:0] data;
   } rx_char_t;

   localparam int CHAR_W = $bits(rx_char_t);

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_START,
      FR_DATA,
      FR_PAR,
      FR_STOP
   } fr_state_e;

endpackage

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              tick
);
   localparam int ACC_W = INT_W + FRAC_W + 1;
   localparam logic [ACC_W-1:0] ONE_CLK = ACC_W'(1) << FRAC_W;

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] period;
   logic [ACC_W-1:0] step_sum;

   assign period   = {1'b0, div_int, div_frac};
   assign step_sum = acc + ONE_CLK;
   assign tick     = !restart && (step_sum >= period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (restart) acc <= period >> 1;
      else if (tick)    acc <= step_sum - period;
      else              acc <= step_sum;
   end

   initial begin
      assert (INT_W >= 2 && FRAC_W >= 1)
         else $error("srx_bit_timer: divisor widths too small");
   end
endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_s,
   input  logic       rx_en,
   input  logic       bit_tick,
   input  logic [1:0] word_len,
   input  logic       parity_en,
   input  logic       parity_even,
   input  logic       two_stop,
   output logic       timer_restart,
   output logic       push,
   output rx_char_t   push_char
);
   fr_state_e         st;
   logic [3:0]        bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              any_one;
   logic              stop_bad;
   logic              stop_cnt;
   logic              rx_prev;

   logic              start_edge;
   logic [3:0]        last_bit;
   logic [DATA_W-1:0] data_al;
   logic              par_calc;
   logic              par_bad;
   logic              any_fin;
   logic              frm_fin;

   assign start_edge    = rx_en && rx_prev && !rx_s;
   assign timer_restart = (st == FR_IDLE) && start_edge;
   assign last_bit      = {2'b00, word_len} + 4'd4;

   assign push = rx_en && bit_tick && (st == FR_STOP) && (!two_stop || stop_cnt);

   // align the shifted-in word to bit 0
   assign data_al  = shreg >> (2'd3 - word_len);
   assign par_calc = ^data_al;
   assign par_bad  = parity_en && (par_bit != (parity_even ? par_calc : !par_calc));
   assign any_fin  = any_one | rx_s;
   assign frm_fin  = stop_bad | !rx_s;

   always_comb begin
      push_char      = '0;
      push_char.data = data_al;
      if (!any_fin)     push_char.brk = 1'b1;
      else if (par_bad) push_char.par = 1'b1;
      else if (frm_fin) push_char.frm = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FR_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         par_bit  <= 1'b0;
         any_one  <= 1'b0;
         stop_bad <= 1'b0;
         stop_cnt <= 1'b0;
         rx_prev  <= 1'b1;
      end else begin
         rx_prev <= rx_s;
         if (!rx_en) begin
            st <= FR_IDLE;
         end else begin
            unique case (st)
               FR_IDLE: begin
                  if (start_edge) begin
                     st       <= FR_START;
                     bit_cnt  <= '0;
                     any_one  <= 1'b0;
                     stop_bad <= 1'b0;
                     stop_cnt <= 1'b0;
                  end
               end
               FR_START: begin
                  if (bit_tick) st <= rx_s ? FR_IDLE : FR_DATA;
               end
               FR_DATA: begin
                  if (bit_tick) begin
                     shreg   <= {rx_s, shreg[DATA_W-1:1]};
                     any_one <= any_one | rx_s;
                     bit_cnt <= bit_cnt + 4'd1;
                     if (bit_cnt == last_bit) st <= parity_en ? FR_PAR : FR_STOP;
                  end
               end
               FR_PAR: begin
                  if (bit_tick) begin
                     par_bit <= rx_s;
                     any_one <= any_one | rx_s;
                     st      <= FR_STOP;
                  end
               end
               FR_STOP: begin
                  if (bit_tick) begin
                     if (two_stop && !stop_cnt) begin
                        stop_cnt <= 1'b1;
                        stop_bad <= frm_fin;
                        any_one  <= any_fin;
                     end else begin
                        st <= FR_IDLE;
                     end
                  end
               end
               default: st <= FR_IDLE;
            endcase
         end
      end
   end

   AST_ONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> $onehot0({push_char.brk, push_char.par, push_char.frm})); // R4
   AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> !push); // R9
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr;
   logic [PTR_W-1:0] rptr;
   logic             wr;
   logic             rd;

   assign empty = (level == '0);
   assign full  = (level == LVL_W'(DEPTH));
   assign wr    = push && !full;
   assign rd    = pop && !empty;
   assign dout  = mem[rptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           mem[i] <= '0;
         else if (wr && wptr == PTR_W'(i))     mem[i] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (wr) wptr <= wptr + PTR_W'(1);
         if (rd) rptr <= rptr + PTR_W'(1);
         unique case ({wr, rd})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("srx_fifo: DEPTH must be a power of two");
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH)); // R7
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push) |=> empty); // R7
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
   import srx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int LEVEL_IRQ   = 8,
   parameter int RTS_LEVEL   = 14,
   parameter int CNT_W       = 16,
   parameter int RTO_W       = 11,
   parameter int INT_W       = 16,
   parameter int FRAC_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   input  logic [1:0]        word_len,
   input  logic              parity_en,
   input  logic              parity_even,
   input  logic              two_stop,
   input  logic              rx_en,
   input  logic              rto_en,
   input  logic [RTO_W-1:0]  rto_limit,
   input  logic              flow_en,
   input  logic              pop,
   input  logic [3:0]        err_clr,
   output logic [CHAR_W-1:0] rd_data,
   output logic [31:0]       status,
   output logic              irq_level,
   output logic              irq_timeout,
   output logic              rts_ready
);
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   logic                   frame_tick;
   logic                   idle_tick;
   logic                   tmr_restart;
   logic                   push_evt;
   rx_char_t               push_char;
   logic                   fifo_empty;
   logic                   fifo_full;
   logic [LVL_W-1:0]       fifo_level;
   logic                   pop_eff;
   logic                   accept;
   logic [3:0]             err_q;
   logic [3:0]             err_set;
   logic [CNT_W-1:0]       rx_cnt;
   logic [RTO_W-1:0]       rto_cnt;
   logic                   rto_hit;

   // input synchroniser, idle level high
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b1;
         else        sync_q[s] <= (s == 0) ? rx_line : sync_q[(s == 0) ? 0 : s - 1];
      end
   end
   assign rx_s = sync_q[SYNC_STAGES-1];

   srx_bit_timer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_frame_tmr (
      .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
      .div_int(div_int), .div_frac(div_frac), .tick(frame_tick)
   );

   srx_bit_timer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_idle_tmr (
      .clk(clk), .rst_n(rst_n), .restart(1'b0),
      .div_int(div_int), .div_frac(div_frac), .tick(idle_tick)
   );

   srx_framer u_framer (
      .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .rx_en(rx_en),
      .bit_tick(frame_tick), .word_len(word_len), .parity_en(parity_en),
      .parity_even(parity_even), .two_stop(two_stop),
      .timer_restart(tmr_restart), .push(push_evt), .push_char(push_char)
   );

   srx_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push_evt), .din(push_char),
      .pop(pop), .dout(rd_data), .empty(fifo_empty), .full(fifo_full),
      .level(fifo_level)
   );

   assign pop_eff = pop && !fifo_empty;
   assign accept  = push_evt && !fifo_full;
   assign err_set = {push_evt && fifo_full,
                     accept && push_char.brk,
                     accept && push_char.par,
                     accept && push_char.frm};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= '0;
         rx_cnt <= '0;
      end else begin
         err_q <= (err_q & ~err_clr) | err_set;
         if (accept) rx_cnt <= rx_cnt + CNT_W'(1);
      end
   end

   // idle timeout counted in free-running bit periods
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rto_cnt <= '0;
         rto_hit <= 1'b0;
      end else if (!rto_en || fifo_empty || push_evt || pop_eff) begin
         rto_cnt <= '0;
         rto_hit <= 1'b0;
      end else if (idle_tick && !rto_hit) begin
         rto_cnt <= rto_cnt + RTO_W'(1);
         if (rto_cnt + RTO_W'(1) >= rto_limit) rto_hit <= 1'b1;
      end
   end

   always_comb begin
      status          = '0;
      status[15:0]    = 16'(rx_cnt);
      status[ST_FRM]  = err_q[0];
      status[ST_PAR]  = err_q[1];
      status[ST_BRK]  = err_q[2];
      status[ST_OVR]  = err_q[3];
      status[ST_EMPT] = fifo_empty;
      status[ST_FULL] = fifo_full;
   end

   assign irq_level   = fifo_level >= LVL_W'(LEVEL_IRQ);
   assign irq_timeout = rto_hit;
   assign rts_ready   = !flow_en || (fifo_level < LVL_W'(RTS_LEVEL));

   initial begin
      assert (LEVEL_IRQ >= 1 && LEVEL_IRQ <= DEPTH)
         else $error("serial_rx_engine: LEVEL_IRQ out of range");
      assert (RTS_LEVEL >= 1 && RTS_LEVEL <= DEPTH)
         else $error("serial_rx_engine: RTS_LEVEL out of range");
      assert (SYNC_STAGES >= 2 && CNT_W >= 1 && CNT_W <= 16 && RTO_W >= 1)
         else $error("serial_rx_engine: bad width parameter");
   end

   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !irq_timeout); // R11
   AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_evt && fifo_full && !pop) |=> (fifo_full && err_q[3])); // R6
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((($past(err_q) & ~$past(err_clr)) & ~err_q) == 4'b0)); // R5
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(rx_cnt)); // R8
endmodule

// File: tb/serial_rx_engine_bench.sv
module serial_rx_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_line = 1'b1;
   logic [15:0] div_int = 16'd16;
   logic [5:0]  div_frac = 6'd0;
   logic [1:0]  wl = 2'd3;
   logic        pe = 1'b0;
   logic        pev = 1'b0;
   logic        ts = 1'b0;
   logic        rx_en = 1'b1;
   logic        rto_en = 1'b0;
   logic [10:0] rto_limit = 11'd8;
   logic        flow_en = 1'b0;
   logic        pop = 1'b0;
   logic [3:0]  err_clr = 4'b0;
   logic [10:0] rd_data;
   logic [31:0] status;
   logic        irq_level;
   logic        irq_timeout;
   logic        rts_ready;

   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [10:0] mq[$];
   int          mcnt = 0;
   logic [3:0]  merr = 4'b0;

   always #5 clk = ~clk;

   serial_rx_engine u_serial_rx_engine (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .div_int(div_int),
      .div_frac(div_frac), .word_len(wl), .parity_en(pe), .parity_even(pev),
      .two_stop(ts), .rx_en(rx_en), .rto_en(rto_en), .rto_limit(rto_limit),
      .flow_en(flow_en), .pop(pop), .err_clr(err_clr), .rd_data(rd_data),
      .status(status), .irq_level(irq_level), .irq_timeout(irq_timeout),
      .rts_ready(rts_ready)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status();
      logic [31:0] s = '0;
      s[15:0] = 16'(mcnt);
      s[19:16] = merr;
      s[24] = (mq.size() == 0);
      s[25] = (mq.size() == 16);
      return s;
   endfunction

   function automatic int bp64();
      return int'(div_int) * 64 + int'(div_frac);
   endfunction

   // bad_stop: 0 none, 1 first stop zero, 2 second stop zero
   task automatic send(input logic [7:0] d, input bit bad_par, input int bad_stop, input bit brk);
      int          nd = int'(wl) + 5;
      int          nb = 0;
      int          ns = ts ? 2 : 1;
      logic [15:0] fr = '1;
      logic [7:0]  dm;
      logic        pb;
      logic        any1 = 1'b0;
      logic        perr = 1'b0;
      logic        ferr = 1'b0;
      logic [10:0] ent;
      dm = brk ? 8'h00 : (d & 8'((1 << nd) - 1));
      fr[0] = 1'b0;
      nb = 1;
      for (int i = 0; i < nd; i++) begin
         fr[nb] = dm[i];
         nb = nb + 1;
      end
      if (pe) begin
         pb = pev ? ^dm : ~^dm;
         if (bad_par) pb = ~pb;
         if (brk) pb = 1'b0;
         perr = (pb != (pev ? ^dm : ~^dm));
         fr[nb] = pb;
         nb = nb + 1;
      end
      for (int s = 0; s < ns; s++) begin
         fr[nb] = (brk || bad_stop == s + 1) ? 1'b0 : 1'b1;
         if (!fr[nb]) ferr = 1'b1;
         nb = nb + 1;
      end
      for (int i = 1; i < nb; i++) any1 = any1 | fr[i];
      for (int t = 0; t * 64 < nb * bp64(); t++) begin
         rx_line = fr[(t * 64) / bp64()];
         @(negedge clk);
      end
      rx_line = 1'b1;
      repeat (2 * int'(div_int)) @(negedge clk);
      ent = {!any1, any1 && perr, any1 && !perr && ferr, dm};
      if (rx_en) begin
         if (mq.size() == 16) merr[3] = 1'b1;
         else begin
            mq.push_back(ent);
            mcnt++;
            merr = merr | {1'b0, ent[10:8]};
         end
      end
   endtask

   task automatic pop_check(input string req);
      logic [10:0] e;
      e = mq.pop_front();
      chk(req, 32'(rd_data), 32'(e));
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear_err(input logic [3:0] m);
      err_clr = m;
      @(negedge clk);
      err_clr = 4'b0;
      merr = merr & ~m;
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0017));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 reset status", status, 32'h0100_0000);
      chk("R8 reset irqs", {30'b0, irq_level, irq_timeout}, 32'h0);
      chk("R12 reset rts", 32'(rts_ready), 32'h1);

      // R1 basic 8N1 and 5-bit
      send(8'hA5, 0, 0, 0); pop_check("R1 8N1");
      wl = 2'd0; send(8'h13, 0, 0, 0); pop_check("R1 5bit");
      wl = 2'd2; send(8'hFF, 0, 0, 0); pop_check("R1 7bit");
      chk("R8 count", status, exp_status());

      // R2 parity
      wl = 2'd3; pe = 1'b1; pev = 1'b1;
      send(8'h37, 0, 0, 0); pop_check("R2 even ok");
      send(8'h37, 1, 0, 0); pop_check("R2 even bad");
      pev = 1'b0; send(8'h81, 1, 0, 0); pop_check("R2 odd bad");
      chk("R5 parity sticky", status, exp_status());

      // R3 framing, second stop checked
      pe = 1'b0; ts = 1'b1;
      send(8'h5C, 0, 2, 0); pop_check("R3 second stop");
      ts = 1'b0; send(8'h5C, 0, 1, 0); pop_check("R3 single stop");

      // R4 break and priority
      pe = 1'b1; pev = 1'b0;
      send(8'h00, 0, 0, 1); pop_check("R4 break over parity");
      send(8'h44, 1, 1, 0); pop_check("R4 parity over framing");
      chk("R5 sticky set", status, exp_status());
      clear_err(4'b0010); chk("R5 clear parity only", status, exp_status());
      clear_err(4'b0101); chk("R5 clear rest", status, exp_status());

      // random mix
      for (int k = 0; k < 30; k++) begin
         wl = 2'($urandom_range(3)); pe = 1'($urandom_range(1));
         pev = 1'($urandom_range(1)); ts = 1'($urandom_range(1));
         send(8'($urandom_range(255)), ($urandom_range(3) == 0),
              ($urandom_range(5) == 0) ? 1 : 0, ($urandom_range(9) == 0));
         pop_check("R1 random frame");
         chk("R5 random status", status, exp_status());
      end
      clear_err(4'b1111);
      wl = 2'd3; pe = 1'b0; ts = 1'b0;

      // R13 glitch
      rx_line = 1'b0; repeat (3) @(negedge clk); rx_line = 1'b1;
      repeat (64) @(negedge clk);
      chk("R13 glitch ignored", status, exp_status());

      // R9 disabled
      rx_en = 1'b0; send(8'h3C, 0, 1, 0); rx_en = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 disabled", status, exp_status());

      // R10 R12 R6 fill
      flow_en = 1'b1;
      for (int k = 0; k < 16; k++) begin
         send(8'(k * 7 + 1), 0, 0, 0);
         chk("R10 level irq", 32'(irq_level), 32'(mq.size() >= 8));
         chk("R12 rts", 32'(rts_ready), 32'(mq.size() < 14));
      end
      send(8'hEE, 0, 0, 0);
      chk("R6 overrun status", status, exp_status());
      flow_en = 1'b0; @(negedge clk);
      chk("R12 flow off", 32'(rts_ready), 32'h1);
      while (mq.size() > 0) pop_check("R6 contents kept");
      clear_err(4'b1000);
      pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
      chk("R7 pop on empty", status, exp_status());

      // R11 timeout
      rto_en = 1'b1; rto_limit = 11'd8;
      repeat (200) @(negedge clk);
      chk("R11 empty no timeout", 32'(irq_timeout), 32'h0);
      send(8'h61, 0, 0, 0);
      chk("R11 early", 32'(irq_timeout), 32'h0);
      repeat (100) @(negedge clk);
      chk("R11 fires", 32'(irq_timeout), 32'h1);
      send(8'h62, 0, 0, 0);
      chk("R11 push restarts", 32'(irq_timeout), 32'h0);
      repeat (100) @(negedge clk);
      pop_check("R11 pop");
      chk("R11 pop restarts", 32'(irq_timeout), 32'h0);
      repeat (50) @(negedge clk);
      chk("R11 still waiting", 32'(irq_timeout), 32'h0);
      repeat (100) @(negedge clk);
      chk("R11 fires again", 32'(irq_timeout), 32'h1);
      rto_en = 1'b0; repeat (2) @(negedge clk);
      chk("R11 disabled", 32'(irq_timeout), 32'h0);
      pop_check("R11 drain");

      // R1 fractional divisor 12.25
      div_int = 16'd12; div_frac = 6'd16;
      pe = 1'b1; pev = 1'b1; ts = 1'b1;
      for (int k = 0; k < 6; k++) begin
         send(8'($urandom_range(255)), 0, 0, 0);
         pop_check("R1 fractional");
      end
      chk("R8 final count", status, exp_status());

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule